// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command-register state machine of a parallel NOR flash. It takes write pulses that have already been qualified on the bus, each with an address and a data byte. From them it decides the device mode: plain array reading, the steps of an unlock sequence, identification (autoselect), program or erase running, erase suspended, or a latched error. It also selects what a read returns. It can return the stored array word, the status word, or the identification word. For reads during a suspended erase, the choice depends on the sector that is addressed.

Program and erase are reached only through unlock sequences. The first write is 0xAA at word address 0x555, the second is 0x55 at 0x2AA, and then a command byte follows. When a sequence completes, the decoder raises one-cycle start, suspend or resume requests to an external program/erase engine. That engine reports back with a done pulse and a timeout pulse. Any write that breaks a sequence sends the decoder back to its base mode. A separate low-supply input from the write qualifier clears everything back to array reading.

Top module: `flashcmd_decoder`

## Requirements
- R1: After reset, mode is 0 (read array) and rd_sel is 0 (array). Array reads need no command.
- R2: The sequence AA@0x555, 55@0x2AA, A0@0x555 moves mode through 1, 2 and 3. The next write sets mode 8 (program busy) and raises start_prog for one cycle. It also latches that write's address on op_addr and its data on op_data.
- R3: Outside suspend, a wrong address or data value inside a sequence returns mode to 0. So does a correct cycle written out of order. A write in mode 0 that is not AA@0x555 leaves mode 0.
- R4: Data 0xF0 at any address returns mode to 0 from the erase setup steps (modes 4, 5 and 6), from autoselect (7) and from error (11).
- R5: The sequence AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA passes through modes 1, 2, 4, 5 and 6. It then ends with one of two writes:
  - 30 at any address sets mode 9 (erase busy) and pulses start_sec_erase.
  - 10@0x555 sets mode 9 and pulses start_chip_erase.
  
  In mode 9, a 0xF0 write is ignored.
- R6: eng_done in mode 9 returns mode to 0. eng_done in mode 8 returns mode to 0, or to 10 if the program was started from suspend.
- R7: Data 0xB0 in mode 9 sets mode 10 (suspended) and pulses req_suspend. Data 0x30 in mode 10 sets mode 9 and pulses req_resume.
- R8: While an erase is suspended, reads return rd_sel 1 (status) when the read address's top SW bits equal the erasing sector. Other reads return 0 (array). If a chip erase is suspended, every read returns 1. The same rule holds after a program run inside suspend has completed.
- R9: eng_timeout in mode 8 or 9 sets mode 11 (error). Mode 11 ignores every write except 0xF0.
- R10: Sequence AA, 55, 90@0x555 sets mode 7 (autoselect) with rd_sel 2 (ident). Writes other than 0xF0 leave mode 7.
- R11: A lowv_rst pulse forces mode 0 on the next edge and aborts any partial sequence.
- R12: In modes 8, 9 and 11, rd_sel is 1 (status) for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lowv_rst | input | 1 | Low-supply reset from the write qualifier, synchronous |
| wr_stb | input | 1 | Qualified write pulse, one cycle |
| wr_addr | input | AW | Write word address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | AW | Current read address |
| eng_done | input | 1 | Engine finished the running operation |
| eng_timeout | input | 1 | Engine exceeded its time limit |
| mode | output | 4 | Decoder mode code |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 ident |
| start_prog | output | 1 | Start-program request pulse |
| start_sec_erase | output | 1 | Start sector-erase request pulse |
| start_chip_erase | output | 1 | Start chip-erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| op_addr | output | AW | Latched program address or erase sector address |
| op_data | output | 8 | Latched program data |

## Verification
The hardest state to reach is a program that completes inside an erase suspend. It needs a full six-write erase sequence, a suspend, a second unlock with a program, and a done pulse. After all that, the bench still has to probe reads inside and outside the suspended sector. The bench scripts this chain cycle by cycle and compares the mode and the request pulses after every event. It also runs the chip-erase variant of suspend, where every read must report status.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    M_READ  = 4'd0,
    M_UNLK1 = 4'd1,
    M_UNLK2 = 4'd2,
    M_PWAIT = 4'd3,
    M_ES0   = 4'd4,
    M_ES1   = 4'd5,
    M_ES2   = 4'd6,
    M_AUTO  = 4'd7,
    M_PBUSY = 4'd8,
    M_EBUSY = 4'd9,
    M_SUSP  = 4'd10,
    M_ERR   = 4'd11
  } fcd_mode_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_STATUS = 2'd1,
    RS_IDENT  = 2'd2
  } fcd_rsel_e;

  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] A_FIRST  = 11'h555;
  localparam logic [CMD_AW-1:0] A_SECOND = 11'h2AA;
  localparam logic [7:0] D_KEY1   = 8'hAA;
  localparam logic [7:0] D_KEY2   = 8'h55;
  localparam logic [7:0] D_RESET  = 8'hF0;
  localparam logic [7:0] D_PROG   = 8'hA0;
  localparam logic [7:0] D_ESETUP = 8'h80;
  localparam logic [7:0] D_SECT   = 8'h30;
  localparam logic [7:0] D_CHIP   = 8'h10;
  localparam logic [7:0] D_SUSP   = 8'hB0;
  localparam logic [7:0] D_IDENT  = 8'h90;

  typedef struct packed {
    logic key1;
    logic key2;
    logic prog;
    logic esetup;
    logic ident;
    logic sect;
    logic chip;
    logic reset;
    logic susp;
  } fcd_evt_t;

  function automatic logic cycle_is(input logic [CMD_AW-1:0] a, input logic [7:0] d,
                                    input logic [CMD_AW-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic sector_hit(input logic [7:0] rd_sec, input logic [7:0] er_sec,
                                      input logic all_sec);
    return all_sec || (rd_sec == er_sec);
  endfunction

endpackage

// File: rtl/fcd_cmd_match.sv
module fcd_cmd_match
  import fcd_pkg::*;
(
  input  logic              wr_stb,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        wr_data,
  output fcd_evt_t          evt
);
  always_comb begin
    evt        = '0;
    evt.key1   = wr_stb && cycle_is(cmd_addr, wr_data, A_FIRST, D_KEY1);
    evt.key2   = wr_stb && cycle_is(cmd_addr, wr_data, A_SECOND, D_KEY2);
    evt.prog   = wr_stb && cycle_is(cmd_addr, wr_data, A_FIRST, D_PROG);
    evt.esetup = wr_stb && cycle_is(cmd_addr, wr_data, A_FIRST, D_ESETUP);
    evt.ident  = wr_stb && cycle_is(cmd_addr, wr_data, A_FIRST, D_IDENT);
    evt.chip   = wr_stb && cycle_is(cmd_addr, wr_data, A_FIRST, D_CHIP);
    evt.sect   = wr_stb && (wr_data == D_SECT);
    evt.reset  = wr_stb && (wr_data == D_RESET);
    evt.susp   = wr_stb && (wr_data == D_SUSP);
  end
endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm
  import fcd_pkg::*;
#(
  parameter int AW = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lowv_rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  fcd_evt_t      evt,
  input  logic          eng_done,
  input  logic          eng_timeout,
  output fcd_mode_e     mode,
  output logic          in_susp,
  output logic [SW-1:0] susp_sec,
  output logic          susp_all,
  output logic          start_prog,
  output logic          start_sec_erase,
  output logic          start_chip_erase,
  output logic          req_suspend,
  output logic          req_resume,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);
  fcd_mode_e nxt, base;
  logic go_prog, go_sec, go_chip, go_susp, go_res;

  always_comb begin
    nxt     = mode;
    base    = in_susp ? M_SUSP : M_READ;
    go_prog = 1'b0;
    go_sec  = 1'b0;
    go_chip = 1'b0;
    go_susp = 1'b0;
    go_res  = 1'b0;
    unique case (mode)
      M_READ:  if (evt.key1) nxt = M_UNLK1;
      M_UNLK1: if (wr_stb) nxt = evt.key2 ? M_UNLK2 : base;
      M_UNLK2: if (wr_stb) begin
        if (evt.prog)                    nxt = M_PWAIT;
        else if (evt.esetup && !in_susp) nxt = M_ES0;
        else if (evt.ident && !in_susp)  nxt = M_AUTO;
        else                             nxt = base;
      end
      M_PWAIT: if (wr_stb) begin
        nxt     = M_PBUSY;
        go_prog = 1'b1;
      end
      M_ES0:   if (wr_stb) nxt = evt.key1 ? M_ES1 : M_READ;
      M_ES1:   if (wr_stb) nxt = evt.key2 ? M_ES2 : M_READ;
      M_ES2:   if (wr_stb) begin
        if (evt.chip) begin
          nxt = M_EBUSY; go_chip = 1'b1;
        end else if (evt.sect) begin
          nxt = M_EBUSY; go_sec = 1'b1;
        end else begin
          nxt = M_READ;
        end
      end
      M_AUTO:  if (evt.reset) nxt = M_READ;
      M_PBUSY: begin
        if (eng_timeout)   nxt = M_ERR;
        else if (eng_done) nxt = base;
      end
      M_EBUSY: begin
        if (eng_timeout)   nxt = M_ERR;
        else if (eng_done) nxt = M_READ;
        else if (evt.susp) begin
          nxt = M_SUSP; go_susp = 1'b1;
        end
      end
      M_SUSP: begin
        if (evt.sect) begin
          nxt = M_EBUSY; go_res = 1'b1;
        end else if (evt.key1) begin
          nxt = M_UNLK1;
        end
      end
      M_ERR:   if (evt.reset) nxt = M_READ;
      default: nxt = M_READ;
    endcase
  end

  // Suspend context survives only through the states reachable from suspend.
  function automatic logic keep_susp(input fcd_mode_e n, input logic cur);
    if (n == M_SUSP) return 1'b1;
    if (n == M_UNLK1 || n == M_UNLK2 || n == M_PWAIT || n == M_PBUSY) return cur;
    return 1'b0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode             <= M_READ;
      in_susp          <= 1'b0;
      susp_sec         <= '0;
      susp_all         <= 1'b0;
      start_prog       <= 1'b0;
      start_sec_erase  <= 1'b0;
      start_chip_erase <= 1'b0;
      req_suspend      <= 1'b0;
      req_resume       <= 1'b0;
      op_addr          <= '0;
      op_data          <= '0;
    end else if (lowv_rst) begin
      mode             <= M_READ;
      in_susp          <= 1'b0;
      start_prog       <= 1'b0;
      start_sec_erase  <= 1'b0;
      start_chip_erase <= 1'b0;
      req_suspend      <= 1'b0;
      req_resume       <= 1'b0;
    end else begin
      mode             <= nxt;
      in_susp          <= keep_susp(nxt, in_susp);
      start_prog       <= go_prog;
      start_sec_erase  <= go_sec;
      start_chip_erase <= go_chip;
      req_suspend      <= go_susp;
      req_resume       <= go_res;
      if (go_prog) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
      if (go_sec || go_chip) begin
        op_addr  <= wr_addr;
        susp_sec <= wr_addr[AW-1 -: SW];
        susp_all <= go_chip;
      end
    end
  end
endmodule

// File: rtl/fcd_read_sel.sv
module fcd_read_sel
  import fcd_pkg::*;
#(
  parameter int SW = 4
) (
  input  fcd_mode_e     mode,
  input  logic          in_susp,
  input  logic [SW-1:0] susp_sec,
  input  logic          susp_all,
  input  logic [SW-1:0] rd_sec,
  output fcd_rsel_e     rd_sel
);
  logic hit;
  assign hit = sector_hit(8'(rd_sec), 8'(susp_sec), susp_all);

  always_comb begin
    unique case (mode)
      M_AUTO:                  rd_sel = RS_IDENT;
      M_PBUSY, M_EBUSY, M_ERR: rd_sel = RS_STATUS;
      default:                 rd_sel = (in_susp && hit) ? RS_STATUS : RS_ARRAY;
    endcase
  end
endmodule

// File: rtl/flashcmd_decoder.sv
module flashcmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lowv_rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          eng_done,
  input  logic          eng_timeout,
  output logic [3:0]    mode,
  output logic [1:0]    rd_sel,
  output logic          start_prog,
  output logic          start_sec_erase,
  output logic          start_chip_erase,
  output logic          req_suspend,
  output logic          req_resume,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);
  fcd_evt_t      evt;
  fcd_mode_e     mode_q;
  fcd_rsel_e     rsel;
  logic          in_susp, susp_all;
  logic [SW-1:0] susp_sec;

  fcd_cmd_match u_match (
    .wr_stb  (wr_stb),
    .cmd_addr(wr_addr[CMD_AW-1:0]),
    .wr_data (wr_data),
    .evt     (evt)
  );

  fcd_fsm #(.AW(AW), .SW(SW)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .lowv_rst        (lowv_rst),
    .wr_stb          (wr_stb),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .evt             (evt),
    .eng_done        (eng_done),
    .eng_timeout     (eng_timeout),
    .mode            (mode_q),
    .in_susp         (in_susp),
    .susp_sec        (susp_sec),
    .susp_all        (susp_all),
    .start_prog      (start_prog),
    .start_sec_erase (start_sec_erase),
    .start_chip_erase(start_chip_erase),
    .req_suspend     (req_suspend),
    .req_resume      (req_resume),
    .op_addr         (op_addr),
    .op_data         (op_data)
  );

  fcd_read_sel #(.SW(SW)) u_rsel (
    .mode    (mode_q),
    .in_susp (in_susp),
    .susp_sec(susp_sec),
    .susp_all(susp_all),
    .rd_sec  (rd_addr[AW-1 -: SW]),
    .rd_sel  (rsel)
  );

  assign mode   = mode_q;
  assign rd_sel = rsel;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       lowv_rst,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic       eng_done,
  input logic       eng_timeout,
  input logic [3:0] mode,
  input logic [1:0] rd_sel,
  input logic       start_prog,
  input logic       start_sec_erase,
  input logic       start_chip_erase,
  input logic       req_suspend,
  input logic       req_resume
);
  a_r2_prog_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |-> mode == M_PBUSY);

  a_r5_erase_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_sec_erase || start_chip_erase) |-> mode == M_EBUSY);

  a_r5_reset_ignored_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_EBUSY && wr_stb && wr_data == D_RESET && !lowv_rst && !eng_done && !eng_timeout)
      |=> mode == M_EBUSY);

  a_r7_suspend_mode: assert property (@(posedge clk) disable iff (!rst_n)
    req_suspend |-> mode == M_SUSP);

  a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_sec_erase, start_chip_erase, req_suspend, req_resume}));

  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERR && !lowv_rst && !(wr_stb && wr_data == D_RESET)) |=> mode == M_ERR);

  a_r10_ident_read: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_AUTO |-> rd_sel == RS_IDENT);

  a_r11_lowv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    lowv_rst |=> mode == M_READ);

  a_r12_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PBUSY || mode == M_EBUSY || mode == M_ERR) |-> rd_sel == RS_STATUS);
endmodule

bind flashcmd_decoder fcd_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .lowv_rst        (lowv_rst),
  .wr_stb          (wr_stb),
  .wr_data         (wr_data),
  .eng_done        (eng_done),
  .eng_timeout     (eng_timeout),
  .mode            (mode),
  .rd_sel          (rd_sel),
  .start_prog      (start_prog),
  .start_sec_erase (start_sec_erase),
  .start_chip_erase(start_chip_erase),
  .req_suspend     (req_suspend),
  .req_resume      (req_resume)
);

// File: tb/flashcmd_decoder_test.sv
`timescale 1ns/1ps
module flashcmd_decoder_test;
  localparam int AW = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lowv_rst = 1'b0, wr_stb = 1'b0, eng_done = 1'b0, eng_timeout = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [3:0]    mode;
  logic [1:0]    rd_sel;
  logic          start_prog, start_sec_erase, start_chip_erase, req_suspend, req_resume;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flashcmd_decoder #(.AW(AW), .SW(SW)) uut (.*);

  typedef struct {
    logic [3:0] m;
    logic [4:0] p;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // Monitor: after any event edge, pop one expectation and compare.
  initial begin
    forever begin
      @(posedge clk);
      if (wr_stb || eng_done || eng_timeout || lowv_rst) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: event with no expectation, actual mode %0d expected item", mode);
        end else begin
          exp_t e;
          logic [4:0] got;
          e = sb.pop_front();
          got = {start_prog, start_sec_erase, start_chip_erase, req_suspend, req_resume};
          checks++;
          if (mode !== e.m || got !== e.p) begin
            errors++;
            $display("FAIL %s: mode=%0d pulses=%b expected mode=%0d pulses=%b",
                     e.tag, mode, got, e.m, e.p);
          end
        end
      end
    end
  end

  task automatic ev(input logic s, input logic [AW-1:0] a, input logic [7:0] d,
                    input logic dn, input logic to, input logic lv,
                    input logic [3:0] em, input logic [4:0] ep, input string tag);
    exp_t e;
    @(negedge clk);
    e.m = em; e.p = ep; e.tag = tag;
    sb.push_back(e);
    wr_stb = s; wr_addr = a; wr_data = d;
    eng_done = dn; eng_timeout = to; lowv_rst = lv;
    @(negedge clk);
    wr_stb = 0; eng_done = 0; eng_timeout = 0; lowv_rst = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic [3:0] em,
                    input logic [4:0] ep, input string tag);
    ev(1'b1, a, d, 1'b0, 1'b0, 1'b0, em, ep, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    checks++;
    if (rd_sel !== exp) begin
      errors++;
      $display("FAIL %s: rd_sel=%0d expected %0d at addr %h", tag, rd_sel, exp, a);
    end
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  localparam logic [4:0] P0 = 5'b00000, PPROG = 5'b10000, PSEC = 5'b01000,
                         PCHIP = 5'b00100, PSUSP = 5'b00010, PRES = 5'b00001;

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode, 0, "R1 reset mode");
    rd(16'h1234, 0, "R1 reset array read");

    // R2 program
    wr(16'h0555, 8'hAA, 1, P0, "R2 unlock1");
    wr(16'h02AA, 8'h55, 2, P0, "R2 unlock2");
    wr(16'h0555, 8'hA0, 3, P0, "R2 prog cmd");
    wr(16'h3456, 8'h12, 8, PPROG, "R2 prog data");
    chk(op_addr, 16'h3456, "R2 op_addr");
    chk(op_data, 8'h12, "R2 op_data");
    rd(16'h0000, 1, "R12 status during program");
    wr(16'h0555, 8'hF0, 8, P0, "R12 write ignored in program");
    ev(0, 0, 0, 1, 0, 0, 0, P0, "R6 program done");

    // R3 wrong sequences
    wr(16'h0555, 8'hAA, 1, P0, "R3 unlock1");
    wr(16'h02AB, 8'h55, 0, P0, "R3 wrong address");
    wr(16'h02AA, 8'h55, 0, P0, "R3 out of order");
    wr(16'h0555, 8'hAA, 1, P0, "R3 unlock1 again");
    wr(16'h02AA, 8'h54, 0, P0, "R3 wrong data");
    wr(16'h0555, 8'hAA, 1, P0, "R3 u1");
    wr(16'h02AA, 8'h55, 2, P0, "R3 u2");
    wr(16'h0555, 8'h77, 0, P0, "R3 bad command");

    // R4 reset between erase cycles
    wr(16'h0555, 8'hAA, 1, P0, "R4 u1");
    wr(16'h02AA, 8'h55, 2, P0, "R4 u2");
    wr(16'h0555, 8'h80, 4, P0, "R4 erase setup");
    wr(16'h0555, 8'hAA, 5, P0, "R4 erase u1");
    wr(16'hBEEF, 8'hF0, 0, P0, "R4 reset any address");

    // R10 autoselect
    wr(16'h0555, 8'hAA, 1, P0, "R10 u1");
    wr(16'h02AA, 8'h55, 2, P0, "R10 u2");
    wr(16'h0555, 8'h90, 7, P0, "R10 enter");
    rd(16'h0001, 2, "R10 ident read");
    wr(16'h0555, 8'hAA, 7, P0, "R10 write ignored");
    wr(16'h0000, 8'hF0, 0, P0, "R4 reset leaves autoselect");
    rd(16'h0001, 0, "R4 array after reset");

    // R5/R7/R8 sector erase, suspend, program in suspend
    wr(16'h0555, 8'hAA, 1, P0, "R5 u1");
    wr(16'h02AA, 8'h55, 2, P0, "R5 u2");
    wr(16'h0555, 8'h80, 4, P0, "R5 setup");
    wr(16'h0555, 8'hAA, 5, P0, "R5 u3");
    wr(16'h02AA, 8'h55, 6, P0, "R5 u4");
    wr(16'h5000, 8'h30, 9, PSEC, "R5 sector confirm");
    wr(16'h0000, 8'hF0, 9, P0, "R5 reset ignored once erasing");
    rd(16'h6000, 1, "R12 status during erase");
    wr(16'h0000, 8'hB0, 10, PSUSP, "R7 suspend");
    rd(16'h5123, 1, "R8 suspended sector status");
    rd(16'h6000, 0, "R8 other sector array");
    wr(16'h0555, 8'hAA, 1, P0, "R8 u1 in suspend");
    wr(16'h0000, 8'h00, 10, P0, "R3 wrong cycle returns to suspend base");
    wr(16'h0555, 8'hAA, 1, P0, "R8 u1");
    wr(16'h02AA, 8'h55, 2, P0, "R8 u2");
    wr(16'h0555, 8'hA0, 3, P0, "R8 prog cmd");
    wr(16'h7000, 8'h77, 8, PPROG, "R8 prog in suspend");
    ev(0, 0, 0, 1, 0, 0, 10, P0, "R6 program done back to suspend");
    rd(16'h5FFF, 1, "R8 suspended sector after program");
    rd(16'h7000, 0, "R8 programmed sector array");
    wr(16'h0000, 8'h30, 9, PRES, "R7 resume");
    ev(0, 0, 0, 1, 0, 0, 0, P0, "R6 erase done");

    // R9 timeout
    wr(16'h0555, 8'hAA, 1, P0, "R9 u1");
    wr(16'h02AA, 8'h55, 2, P0, "R9 u2");
    wr(16'h0555, 8'hA0, 3, P0, "R9 cmd");
    wr(16'h0100, 8'h01, 8, PPROG, "R9 prog");
    ev(0, 0, 0, 0, 1, 0, 11, P0, "R9 timeout to error");
    rd(16'h0100, 1, "R12 status in error");
    wr(16'h0555, 8'hAA, 11, P0, "R9 unlock ignored in error");
    wr(16'h0000, 8'hF0, 0, P0, "R9 reset leaves error");

    // R5/R8 chip erase and suspend
    wr(16'h0555, 8'hAA, 1, P0, "R5 c u1");
    wr(16'h02AA, 8'h55, 2, P0, "R5 c u2");
    wr(16'h0555, 8'h80, 4, P0, "R5 c setup");
    wr(16'h0555, 8'hAA, 5, P0, "R5 c u3");
    wr(16'h02AA, 8'h55, 6, P0, "R5 c u4");
    wr(16'h0555, 8'h10, 9, PCHIP, "R5 chip confirm");
    wr(16'h0000, 8'hB0, 10, PSUSP, "R7 chip suspend");
    rd(16'h0000, 1, "R8 chip suspended status a");
    rd(16'hF000, 1, "R8 chip suspended status b");
    wr(16'h0000, 8'h30, 9, PRES, "R7 chip resume");
    ev(0, 0, 0, 1, 0, 0, 0, P0, "R6 chip done");

    // R3 bad confirm, R11 low supply
    wr(16'h0555, 8'hAA, 1, P0, "R3 b u1");
    wr(16'h02AA, 8'h55, 2, P0, "R3 b u2");
    wr(16'h0555, 8'h80, 4, P0, "R3 b setup");
    wr(16'h0555, 8'hAA, 5, P0, "R3 b u3");
    wr(16'h02AA, 8'h55, 6, P0, "R3 b u4");
    wr(16'h0555, 8'h20, 0, P0, "R3 bad confirm");
    wr(16'h0555, 8'hAA, 1, P0, "R11 u1");
    wr(16'h02AA, 8'h55, 2, P0, "R11 u2");
    wr(16'h0555, 8'h80, 4, P0, "R11 setup");
    ev(0, 0, 0, 0, 0, 1, 0, P0, "R11 low supply aborts");
    wr(16'h02AA, 8'h55, 0, P0, "R11 sequence really aborted");

    repeat (3) @(negedge clk);
    chk(sb.size(), 0, "scoreboard drained");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule